// File: doc/BRIEF.md
# Offset Correction Sequencer

This block decides when an internal offset-calibration cycle runs and reports it on a status/request output. A cycle can start for four reasons: power-up, the supply coming back after a droop, the sleep bit being cleared, or the correction-request bit being set. While a cycle runs, the block forces the operating mode to low-reflectivity read and tells the gain registers to use their maximum code. When the cycle completes, it sends a one-cycle pulse to the register block. That pulse restores the gain defaults and clears the request bit.

A supply droop has priority over every other condition. It aborts a running cycle, and nothing starts again until the supply-recovered flag is seen. A temperature-change event after the first completed cycle raises the status output. The block does not start a cycle on its own in that case; it waits for a request.

The block keeps the running of a cycle separate from whether its result is visible. When both mode pins are high, correction is inactive. A cycle that completes in that state leaves the output flagged as uncorrected. Once the output has been flagged uncorrected, it stays that way until another cycle completes in an active mode. The cycle length is a parameter: about 150 ms of clock cycles in the chip, and a few cycles in simulation.

Top module: `offset_cal_seq`

## Requirements
- R1: After reset is released, a correction cycle of exactly CAL_CYCLES clocks runs without any trigger. statusOut is high during reset and throughout the cycle.
- R2: From idle, a set correction-request bit starts a cycle at the next clock. Clearing the sleep bit while asleep also starts a cycle at the next clock. A supply-recovered flag seen while waiting after a droop also starts a cycle at the next clock. Each such cycle ends with its completion pulse CAL_CYCLES+1 clocks after the trigger edge.
- R3: When the sleep bit and the correction-request bit are both set in idle, the block enters sleep and no cycle starts. statusOut and gainForceMax stay low.
- R4: While a cycle runs, gainForceMax is 1 (maximum gain, code 0000) and effMode is 2'b00 (low-reflectivity read), whatever the pins say.
- R5: On completion, restorePulse and clearReqPulse are high for exactly one clock, and statusOut drops in that same clock unless a temperature event is pending.
- R6: supplyLow during a cycle aborts it at the next clock: statusOut and gainForceMax go low and no completion pulse is given. No cycle begins until supplyOk is seen with supplyLow low.
- R7: After the first completed cycle, a tempShift pulse raises statusOut at the next clock with no cycle running. statusOut stays high until a request starts a cycle.
- R8: Outside a cycle, effMode decodes the pins as follows: pinWrite=1 gives 2'b10 (write), pinWrite=0 with pinMode=1 gives 2'b01 (high-reflectivity read), and both low give 2'b00.
- R9: Correction is inactive when both pins are high; this clears corrValid at the next clock. When a cycle completes, corrValid becomes 1 only if the mode is active at that moment. Otherwise corrValid stays 0, even after the mode becomes active again, until a later cycle completes while active.
- R10: The cycle counter never exceeds CAL_CYCLES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| supplyLow | input | 1 | Supply droop comparator flag |
| supplyOk | input | 1 | Supply recovered comparator flag |
| sleepBit | input | 1 | Sleep control bit from the register block |
| calReqBit | input | 1 | Correction request bit from the register block |
| tempShift | input | 1 | Temperature-change event |
| pinWrite | input | 1 | Read/write select pin |
| pinMode | input | 1 | Reflectivity select pin |
| statusOut | output | 1 | High while correcting or while a temperature request is pending |
| gainForceMax | output | 1 | Gain registers use maximum code while high |
| effMode | output | 2 | Effective operating mode (00 low-refl read, 01 high-refl read, 10 write) |
| restorePulse | output | 1 | One-clock request to reload gain defaults |
| clearReqPulse | output | 1 | One-clock request to clear the correction-request bit |
| corrValid | output | 1 | Output reflects a completed, visible correction |

## Verification
All state changes are registered, so a trigger applied before a rising edge shows on statusOut and gainForceMax at the following falling edge. The completion pulse arrives CAL_CYCLES+1 edges after a trigger, or CAL_CYCLES edges after reset release. effMode is combinational from the pins and the state, so it is checked one falling edge after the pins change. The bench drives inputs and samples outputs only on falling edges. It counts edges from each trigger to the pulse and compares the count with those figures.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DONE  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAIT  = 3'd4
  } seqState_t;

  typedef enum logic [1:0] {
    MODE_RD_LOW  = 2'b00,
    MODE_RD_HIGH = 2'b01,
    MODE_WR      = 2'b10
  } opMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic applyLoad;
    logic applyClear;
  } dpCtl_t;
endpackage

// File: rtl/ocs_dp.sv
module ocs_dp
  import ocs_pkg::*;
#(
  parameter int CAL_CYCLES = 7_500_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtl_t  ctl,
  input  logic    pinWrite,
  input  logic    pinMode,
  output logic    cntLast,
  output logic    modeActive,
  output opMode_t pinModeDec,
  output logic    corrValid
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.cntClear) cnt <= '0;
    else if (ctl.cntStep)  cnt <= cnt + 1'b1;
  end

  assign cntLast    = (cnt == LAST);
  assign modeActive = !(pinWrite && pinMode);

  always_comb begin
    if (pinWrite)     pinModeDec = MODE_WR;
    else if (pinMode) pinModeDec = MODE_RD_HIGH;
    else              pinModeDec = MODE_RD_LOW;
  end

  // visibility of the correction result at the output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               corrValid <= 1'b0;
    else if (!modeActive)    corrValid <= 1'b0;
    else if (ctl.applyClear) corrValid <= 1'b0;
    else if (ctl.applyLoad)  corrValid <= 1'b1;
  end

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  assert_inactive_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> !corrValid);
endmodule

// File: rtl/ocs_ctrl.sv
module ocs_ctrl
  import ocs_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   supplyLow,
  input  logic   supplyOk,
  input  logic   sleepBit,
  input  logic   calReqBit,
  input  logic   tempShift,
  input  logic   cntLast,
  output dpCtl_t ctl,
  output logic   isRun,
  output logic   isDone,
  output logic   tempPending
);
  seqState_t state, nextState;
  logic doneOnce;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:   if (supplyLow) nextState = ST_WAIT;
                else if (cntLast) nextState = ST_DONE;
      ST_DONE:  nextState = supplyLow ? ST_WAIT : ST_IDLE;
      ST_IDLE:  if (supplyLow) nextState = ST_WAIT;
                else if (sleepBit) nextState = ST_SLEEP;
                else if (calReqBit) nextState = ST_RUN;
      ST_SLEEP: if (supplyLow) nextState = ST_WAIT;
                else if (!sleepBit) nextState = ST_RUN;
      ST_WAIT:  if (supplyOk && !supplyLow)
                  nextState = sleepBit ? ST_SLEEP : ST_RUN;
      default:  nextState = ST_IDLE;
    endcase
  end

  // power-up counts as a trigger: reset lands in RUN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 doneOnce <= 1'b0;
    else if (state == ST_DONE) doneOnce <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      tempPending <= 1'b0;
    else if (state == ST_RUN)       tempPending <= 1'b0;
    else if (tempShift && doneOnce) tempPending <= 1'b1;
  end

  assign isRun  = (state == ST_RUN);
  assign isDone = (state == ST_DONE);

  always_comb begin
    ctl.cntStep    = isRun && !cntLast;
    ctl.cntClear   = !ctl.cntStep;
    ctl.applyLoad  = isRun && cntLast && !supplyLow;
    ctl.applyClear = !isRun && (nextState == ST_RUN);
  end

  assert_sleep_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && sleepBit && calReqBit && !supplyLow) |=> state == ST_SLEEP);

  assert_droop_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && supplyLow) |=> state == ST_WAIT);

  assert_no_selfstart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !calReqBit && !sleepBit && !supplyLow) |=> state != ST_RUN);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> state != ST_DONE);
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocs_pkg::*;
#(
  parameter int CAL_CYCLES = 7_500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyLow,
  input  logic       supplyOk,
  input  logic       sleepBit,
  input  logic       calReqBit,
  input  logic       tempShift,
  input  logic       pinWrite,
  input  logic       pinMode,
  output logic       statusOut,
  output logic       gainForceMax,
  output logic [1:0] effMode,
  output logic       restorePulse,
  output logic       clearReqPulse,
  output logic       corrValid
);
  dpCtl_t  ctl;
  logic    cntLast, modeActive, isRun, isDone, tempPending;
  opMode_t pinModeDec;

  ocs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .supplyOk(supplyOk),
    .sleepBit(sleepBit), .calReqBit(calReqBit), .tempShift(tempShift),
    .cntLast(cntLast), .ctl(ctl), .isRun(isRun), .isDone(isDone),
    .tempPending(tempPending)
  );

  ocs_dp #(.CAL_CYCLES(CAL_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pinWrite(pinWrite), .pinMode(pinMode),
    .cntLast(cntLast), .modeActive(modeActive), .pinModeDec(pinModeDec),
    .corrValid(corrValid)
  );

  assign statusOut     = isRun || tempPending;
  assign gainForceMax  = isRun;
  assign effMode       = isRun ? MODE_RD_LOW : pinModeDec;
  assign restorePulse  = isDone;
  assign clearReqPulse = isDone;

  assert_pulse_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    restorePulse |-> clearReqPulse && !gainForceMax);
endmodule

// File: tb/offset_cal_seq_tb_top.sv
module offset_cal_seq_tb_top;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 0, supplyOk = 0, sleepBit = 0, calReqBit = 0, tempShift = 0;
  logic pinWrite = 0, pinMode = 0;
  logic statusOut, gainForceMax, restorePulse, clearReqPulse, corrValid;
  logic [1:0] effMode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  offset_cal_seq #(.CAL_CYCLES(N)) dut_i (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .supplyOk(supplyOk),
    .sleepBit(sleepBit), .calReqBit(calReqBit), .tempShift(tempShift),
    .pinWrite(pinWrite), .pinMode(pinMode), .statusOut(statusOut),
    .gainForceMax(gainForceMax), .effMode(effMode), .restorePulse(restorePulse),
    .clearReqPulse(clearReqPulse), .corrValid(corrValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges up to the completion pulse; checks forcing on the way
  task automatic runCount(input string req, input int expCnt);
    int n = 0;
    int forceBad = 0;
    do begin
      @(negedge clk);
      n++;
      if (!restorePulse && (!gainForceMax || effMode != 2'b00 || !statusOut))
        forceBad++;
    end while (!restorePulse && n < 50);
    calReqBit = 0;
    chk({req, " cycles to completion"}, n, expCnt);
    chk("R4 forcing during run", forceBad, 0);
    chk("R5 clear pulse with restore", clearReqPulse, 1);
    chk("R5 status low at completion", statusOut, 0);
    @(negedge clk);
    chk("R5 pulse one clock", restorePulse, 0);
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", statusOut, 1);
    chk("R4 reset force", gainForceMax, 1);
    chk("R5 reset pulse", restorePulse, 0);
    chk("R9 reset corrValid", corrValid, 0);
    rstN = 1;
    runCount("R1 power-up", N);
    chk("R9 visible after active run", corrValid, 1);

    // R8 mode decode sweep
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 2; m++) begin
        pinWrite = w[0]; pinMode = m[0];
        @(negedge clk);
        chk("R8 mode decode", effMode, w ? 2 : (m ? 1 : 0));
      end
    pinWrite = 0; pinMode = 0;
    @(negedge clk);
    chk("R9 stays uncorrected after inactive", corrValid, 0);

    // R2 request trigger with high-reflectivity pins
    pinMode = 1;
    calReqBit = 1;
    runCount("R2 request", N + 1);
    chk("R8 mode after run", effMode, 1);
    chk("R9 active at completion", corrValid, 1);
    pinMode = 0;

    // R3 sleep priority
    sleepBit = 1; calReqBit = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 sleep wins status", statusOut, 0);
      chk("R3 sleep wins force", gainForceMax, 0);
    end
    calReqBit = 0;
    @(negedge clk);
    sleepBit = 0;
    runCount("R2 sleep exit", N + 1);

    // R6 droop abort, then recovery
    calReqBit = 1;
    repeat (3) @(negedge clk);
    chk("R6 running before droop", gainForceMax, 1);
    supplyLow = 1; calReqBit = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 aborted status", statusOut, 0);
      chk("R6 no completion", restorePulse, 0);
    end
    supplyLow = 0;
    repeat (3) @(negedge clk);
    chk("R6 no start before recovery", statusOut, 0);
    supplyOk = 1;
    @(negedge clk);
    supplyOk = 0;
    chk("R2 recovery starts run", gainForceMax, 1);
    runCount("R2 recovery", N);

    // R7 temperature event
    tempShift = 1;
    @(negedge clk);
    tempShift = 0;
    chk("R7 status raised", statusOut, 1);
    chk("R7 no run", gainForceMax, 0);
    repeat (5) @(negedge clk);
    chk("R7 still waiting", statusOut, 1);
    chk("R7 no self start", gainForceMax, 0);
    calReqBit = 1;
    runCount("R7 request clears", N + 1);

    // R9 inactive run: complete while inactive
    pinWrite = 1; pinMode = 1;
    @(negedge clk);
    chk("R9 inactive clears", corrValid, 0);
    calReqBit = 1;
    runCount("R9 inactive run", N + 1);
    chk("R9 not visible", corrValid, 0);
    pinWrite = 0; pinMode = 0;
    repeat (2) @(negedge clk);
    chk("R9 stays uncorrected", corrValid, 0);
    // inactive start, re-activated before the end
    pinWrite = 1; pinMode = 1;
    calReqBit = 1;
    repeat (2) @(negedge clk);
    pinWrite = 0; pinMode = 0;
    runCount("R9 reactivated run", N - 1);
    chk("R9 visible after reactivation", corrValid, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule